// File: doc/BRIEF.md
# Asynchronous Parallel Word Receiver

This block takes a parallel data word that arrives together with the clock of the transmitter that produced it. Neither is related to the local system clock. The transmitter changes the word on every edge of its clock, rising or falling. The word then stays stable for a guaranteed window after that edge. The receiver registers the whole bus on every system clock edge. It also samples the transmitter clock through two flip-flops in series. When those two samples disagree, the transmitter clock has changed, and the freshly registered word is announced with a one-cycle valid flag.

The system clock period must be shorter than the window during which the transmitted word is stable. This guarantees that at least one system edge falls inside every window. It also guarantees that the edge which first sees a new transmitter clock level captures the word that belongs to that level. Downstream logic only needs to take `rx_data` in the cycles where `rx_valid` is high. It then receives each transmitted word exactly once and in transmission order.

Top module: `async_word_rx`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, both transmitter clock samples and the data register are cleared. From the following cycle `rx_valid` is 0 and `rx_data` is all zeros, whatever the inputs are.
- R2: Out of reset, `rx_data` after every rising `clk` edge equals the value of `tx_data` at that edge, whether or not a word is being announced.
- R3: The transmitter clock is sampled twice in series. `rx_valid` in the cycle after edge n is 1 exactly when the levels of `tx_clk` seen at edges n and n-1 differ. A sampled level other than logic 1 is taken as 0.
- R4: A rising and a falling transition of `tx_clk` each produce a valid pulse, and they do so in the same way.
- R5: Each transition of `tx_clk` that lasts at least one system clock period yields exactly one cycle of `rx_valid`. When both levels last longer than two periods, `rx_valid` is never high in two consecutive cycles.
- R6: In every cycle where `rx_valid` is 1, `rx_data` holds the word that the transmitter presented with the `tx_clk` edge being announced.
- R7: Over a run, the words delivered under `rx_valid` are exactly the transmitted words, each once and in transmission order.
- R8: A change of `tx_data` that comes without a `tx_clk` transition never raises `rx_valid`.
- R9: The bus width is the parameter `DATA_W`, with a default of 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset, sampled on `clk` |
| tx_data | input | DATA_W | Parallel word from the transmitter, asynchronous to `clk` |
| tx_clk | input | 1 | Transmitter clock; each of its edges introduces a new word |
| rx_data | output | DATA_W | Word registered on the most recent `clk` edge |
| rx_valid | output | 1 | One-cycle flag: `rx_data` holds a newly announced word |

## Verification
`rx_data` is due one edge after the bus is sampled. `rx_valid` follows a `tx_clk` transition by one or two edges, depending on where the transition falls between system edges. It rises in the cycle after the first edge that sees the new level, and it falls one edge later.

The bench drives every input a fraction of a nanosecond away from the clock grid. Its reference records the inputs at each rising edge and derives the due values from those records. All outputs are compared at the falling edge, so each comparison lands in the cycle where the value is due, without counting on a fixed delay from the transmitter edge.

Word order and uniqueness are checked against a queue that the transmitter fills.

// File: rtl/async_word_rx_pkg.sv
package async_word_rx_pkg;

  // Number of series samples taken of the transmitter clock.
  localparam int unsigned TXCLK_TAPS = 2;

  // Interpret a sampled transmitter clock level: only a clean 1 counts as 1.
  function automatic logic clean_level(input logic lvl);
    return (lvl === 1'b1) ? 1'b1 : 1'b0;
  endfunction

  // A new word is announced when two successive level samples disagree.
  function automatic logic level_moved(input logic newer, input logic older);
    return newer ^ older;
  endfunction

endpackage

// File: rtl/awr_word_reg.sv
module awr_word_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  // One flip-flop per bus bit, each sampling on every clock edge.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic bit_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else begin
        bit_q <= d[b];
      end
    end

    assign q[b] = bit_q;
  end

endmodule

// File: rtl/awr_clk_sampler.sv
module awr_clk_sampler
  import async_word_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_clk,
  output logic lvl_q1,
  output logic lvl_q2
);

  logic [TXCLK_TAPS-1:0] taps;

  // Stage 0 takes the raw level, with anything that is not a clean 1 taken as 0.
  // Each later stage copies the stage before it.
  for (genvar s = 0; s < TXCLK_TAPS; s++) begin : g_tap
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          taps[0] <= 1'b0;
        end else begin
          taps[0] <= clean_level(tx_clk);
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          taps[s] <= 1'b0;
        end else begin
          taps[s] <= taps[s-1];
        end
      end
    end
  end

  assign lvl_q1 = taps[0];
  assign lvl_q2 = taps[TXCLK_TAPS-1];

endmodule

// File: rtl/awr_edge_flag.sv
module awr_edge_flag
  import async_word_rx_pkg::*;
(
  input  logic lvl_new,
  input  logic lvl_old,
  output logic strobe
);

  // Either direction of change raises the strobe for one cycle (R4).
  always_comb begin
    strobe = level_moved(lvl_new, lvl_old);
  end

endmodule

// File: rtl/async_word_rx.sv
module async_word_rx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_clk,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);

  // Named internal events, brought out for the bound checker.
  logic tx_lvl_q1;
  logic tx_lvl_q2;
  logic word_strobe;

  // The bus is captured on the same edge as the first clock sample,
  // so the word and its strobe line up (R6).
  awr_word_reg #(.WIDTH(DATA_W)) u_word (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (tx_data),
    .q     (rx_data)
  );

  awr_clk_sampler u_sampler (
    .clk    (clk),
    .rst_n  (rst_n),
    .tx_clk (tx_clk),
    .lvl_q1 (tx_lvl_q1),
    .lvl_q2 (tx_lvl_q2)
  );

  awr_edge_flag u_edge (
    .lvl_new (tx_lvl_q1),
    .lvl_old (tx_lvl_q2),
    .strobe  (word_strobe)
  );

  assign rx_valid = word_strobe;

endmodule

// File: rtl/awr_checker.sv
module awr_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] tx_data,
  input logic         tx_clk,
  input logic [W-1:0] rx_data,
  input logic         rx_valid,
  input logic         s1,
  input logic         s2
);

  // Cycles since reset was released, saturating; keeps $past inside history.
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_rst <= 2'd0;
    end else if (since_rst != 2'd3) begin
      since_rst <= since_rst + 2'd1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rx_valid && rx_data == '0));

  p_data_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd1) |-> (rx_data == $past(tx_data)));

  p_first_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd1) |-> (s1 == $past(tx_clk)));

  p_second_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd1) |-> (s2 == $past(s1)));

  p_valid_on_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (rx_valid == ($past(tx_clk) != $past(tx_clk, 2))));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && rx_valid && $past(rx_valid)) |-> (s1 != $past(s1)));

endmodule

bind async_word_rx awr_checker #(.W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_data  (tx_data),
  .tx_clk   (tx_clk),
  .rx_data  (rx_data),
  .rx_valid (rx_valid),
  .s1       (tx_lvl_q1),
  .s2       (tx_lvl_q2)
);

// File: tb/sim_async_word_rx.sv
`timescale 1ns/100ps
module sim_async_word_rx;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic         tx_clk = 1'b0;
  wire  [W-1:0] rx_data;
  wire          rx_valid;

  async_word_rx #(.DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_clk(tx_clk),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [W-1:0] sent_q[$];
  int n_sent = 0, n_rise_sent = 0, n_seen = 0, n_rise_seen = 0;
  bit slow_mode = 1'b1;
  bit started = 1'b0;
  bit prev_valid = 1'b0;

  // Reference: levels of tx_clk seen at the latest two edges, word seen at the latest edge.
  bit           seen_now = 1'b0, seen_before = 1'b0;
  logic [W-1:0] exp_data = '0;
  bit           exp_valid = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    started = 1'b1;
    if (!rst_n) begin
      seen_now = 1'b0; seen_before = 1'b0; exp_data = '0;
    end else begin
      seen_before = seen_now;
      seen_now    = tx_clk;
      exp_data    = tx_data;
    end
    exp_valid = (seen_now != seen_before);
    if (cycles == 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      if (!rst_n) begin
        check(rx_valid == 1'b0, "R1", "valid in reset", rx_valid, 0);
        check(rx_data == '0, "R1", "data in reset", rx_data, 0);
      end else begin
        check(rx_data == exp_data, "R2", "registered word", rx_data, exp_data);
        check(rx_valid == exp_valid, "R3", "valid vs two samples", rx_valid, exp_valid);
        if (slow_mode && rx_valid && prev_valid)
          check(1'b0, "R5", "back-to-back valid", 1, 0);
        if (rx_valid) begin
          n_seen++;
          if (seen_now) n_rise_seen++;
          if (sent_q.size() == 0) begin
            check(1'b0, "R8", "valid with no word sent", rx_data, 0);
          end else begin
            logic [W-1:0] want;
            want = sent_q.pop_front();
            check(rx_data == want, "R6", "announced word", rx_data, want);
          end
        end
      end
      prev_valid = rx_valid;
    end
  end

  task automatic send_word(input int half_ns, input bit noisy);
    logic [W-1:0] w;
    w = W'($urandom);
    tx_data = w;
    tx_clk  = ~tx_clk;
    sent_q.push_back(w);
    n_sent++;
    if (tx_clk) n_rise_sent++;
    if (noisy) begin
      #17;
      tx_data = W'($urandom);   // R8: bus moves with no transmitter clock edge
      #(half_ns - 17);
    end else begin
      #(half_ns);
    end
  endtask

  initial begin
    tx_data = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #3.3;
    #($urandom_range(0, 9));
    // Slow transmitter clock with random phase.
    for (int i = 0; i < 40; i++) send_word($urandom_range(23, 61), 1'b0);
    // Bus noise between transmitter edges.
    for (int i = 0; i < 30; i++) send_word($urandom_range(30, 60), 1'b1);
    // Transmitter half period just above one system period.
    slow_mode = 1'b0;
    for (int i = 0; i < 40; i++) send_word($urandom_range(12, 14), 1'b0);
    repeat (6) @(negedge clk);
    check(n_seen == n_sent, "R7", "words delivered", n_seen, n_sent);
    check(sent_q.size() == 0, "R7", "words left undelivered", sent_q.size(), 0);
    check(n_rise_seen == n_rise_sent, "R4", "rising-edge words", n_rise_seen, n_rise_sent);
    check((n_sent - n_rise_sent) == (n_seen - n_rise_seen), "R5", "falling-edge words",
          n_seen - n_rise_seen, n_sent - n_rise_sent);
    check($bits(rx_data) == W, "R9", "bus width", $bits(rx_data), W);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule